// File: doc/BRIEF.md
# Protected-Zone Access Ordering Unit

This unit sits between the memory-request stage of a pipelined processor and a single data bus. The pipeline offers a write stream and a read stream. A write and a read presented in the same cycle are treated as a write followed by a younger read. Writes are parked in a small queue, so reads normally reach the bus first. That read-first behaviour is fast, but it breaks peripherals that expect their registers to see accesses in program order.

A set of address zones, each bounded by an inclusive base and limit, can be marked as protected. When the younger read, or any write still waiting ahead of it, falls in an enabled zone, the unit stalls the read until every older write has gone out on the bus. Only those cases cost extra cycles. All other traffic keeps the read-first path with no stall. A small enable register chooses which zones are protected, and after reset every zone is protected.

Top module: `pzo_order_unit`

## Requirements
- R1: After reset, bus_valid, rd_stall and wr_stall are 0, and every zone is protected (the enable register holds all ones).
- R2: A write and a read outside every enabled zone, presented in the same cycle, appear on the bus read first and write second, with rd_stall never asserted.
- R3: When a write is pending (queued or arriving in the same cycle) and either the read or a pending write lies in an enabled zone, rd_stall stays high until all older writes have been issued. Such a same-cycle pair appears on the bus write first and then read, with exactly 2 stall cycles.
- R4: An address is in zone z when ZBASE[z] <= addr <= ZLIMIT[z], with both ends inclusive. With the default parameters, zone 0 spans 0x1000 to 0x1FFF and zone 1 spans 0x6000 to 0x6FFF.
- R5: When cfg_we is high at a clock edge, the enable register loads cfg_en (bit z is zone z). A disabled zone behaves as unprotected, and the other zones stay protected.
- R6: When the write queue holds DEPTH entries, wr_stall is high, a queued write is issued with priority, and a valid read is stalled in that cycle.
- R7: Writes reach the bus in acceptance order, with their addresses and data unchanged.
- R8: A read accepted in a cycle (rd_valid high and rd_stall low) appears on the bus in the next cycle with bus_we low. The unit issues at most one bus transaction per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Load the zone enable register |
| cfg_en | input | NZONES | New zone enable bits, one per zone |
| wr_valid | input | 1 | Write request present |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Write data |
| wr_stall | output | 1 | Write not accepted this cycle (queue full) |
| rd_valid | input | 1 | Read request present; held while stalled |
| rd_addr | input | AW | Read address |
| rd_stall | output | 1 | Read not accepted this cycle |
| bus_valid | output | 1 | Bus transaction present (registered) |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | AW | Bus address |
| bus_wdata | output | DW | Bus write data (0 for reads) |

## Verification
The hardest situation to reach is a full write queue while reads keep arriving, because the unit normally lets every unprotected read go ahead. The bench gets there by streaming writes and unprotected reads together, one of each per cycle, so the queue grows by one each cycle until it fills. It then checks that the read is held back while a write drains, and that every write still leaves in order. Zone edges are exercised with reads exactly at a limit and writes exactly at a base, paired with addresses one step outside the zone.

// File: rtl/pzo_pkg.sv
package pzo_pkg;
  typedef enum logic {OP_RD = 1'b0, OP_WR = 1'b1} bus_op_e;

  function automatic logic in_window(input logic [31:0] a, input logic [31:0] lo,
                                     input logic [31:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction
endpackage

// File: rtl/pzo_zone_match.sv
module pzo_zone_match #(
  parameter int AW = 16,
  parameter int NZ = 2,
  parameter logic [NZ*AW-1:0] ZBASE  = '0,
  parameter logic [NZ*AW-1:0] ZLIMIT = '0
) (
  input  logic [AW-1:0] addr,
  input  logic [NZ-1:0] zone_on,
  output logic          hit
);
  logic [NZ-1:0] per_zone;

  generate
    for (genvar z = 0; z < NZ; z++) begin : g_zone
      assign per_zone[z] = zone_on[z] &&
        pzo_pkg::in_window(32'(addr), 32'(ZBASE[z*AW +: AW]), 32'(ZLIMIT[z*AW +: AW]));
    end
  endgenerate

  assign hit = |per_zone;
endmodule

// File: rtl/pzo_wfifo.sv
module pzo_wfifo #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int DEPTH = 4,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic [DW-1:0] push_data,
  input  logic          push_prot,
  input  logic          pop,
  output logic [AW-1:0] head_addr,
  output logic [DW-1:0] head_data,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] prot_cnt
);
  logic [AW-1:0] mem_a [DEPTH];
  logic [DW-1:0] mem_d [DEPTH];
  logic          mem_p [DEPTH];
  logic [PW-1:0] wp, rp;
  logic          head_prot;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) begin
      mem_a[wp] <= push_addr;
      mem_d[wp] <= push_data;
      mem_p[wp] <= push_prot;
    end
  end

  assign head_addr = mem_a[rp];
  assign head_data = mem_d[rp];
  assign head_prot = mem_p[rp];

  always_ff @(posedge clk) begin
    if (rst) begin
      wp       <= '0;
      rp       <= '0;
      cnt      <= '0;
      prot_cnt <= '0;
    end else begin
      if (push) wp <= step(wp);
      if (pop)  rp <= step(rp);
      cnt      <= cnt + CW'(push) - CW'(pop);
      prot_cnt <= prot_cnt + CW'(push && push_prot) - CW'(pop && head_prot);
    end
  end
endmodule

// File: rtl/pzo_arb.sv
module pzo_arb #(
  parameter int DEPTH = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          rd_valid,
  input  logic          rd_hit,
  input  logic          wr_valid,
  input  logic          wr_hit,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] prot_cnt,
  output logic          push,
  output logic          rd_go,
  output logic          wr_go,
  output logic          rd_stall,
  output logic          wr_stall
);
  logic full, pend_any, pend_prot, rd_block;

  always_comb begin
    full      = (cnt == CW'(DEPTH));
    push      = wr_valid && !full;
    pend_any  = (cnt != '0) || push;
    pend_prot = (prot_cnt != '0) || (push && wr_hit);
    rd_block  = pend_any && (rd_hit || pend_prot);
    rd_go     = rd_valid && !rd_block && !full;
    wr_go     = !rd_go && (cnt != '0);
    rd_stall  = rd_valid && !rd_go;
    wr_stall  = full;
  end
endmodule

// File: rtl/pzo_order_unit.sv
module pzo_order_unit #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int DEPTH = 4,
  parameter int NZONES = 2,
  parameter logic [NZONES*AW-1:0] ZBASE  = {16'h6000, 16'h1000},
  parameter logic [NZONES*AW-1:0] ZLIMIT = {16'h6FFF, 16'h1FFF},
  parameter logic [NZONES-1:0]    EN_RESET = '1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [NZONES-1:0] cfg_en,
  input  logic              wr_valid,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DW-1:0]     wr_data,
  output logic              wr_stall,
  input  logic              rd_valid,
  input  logic [AW-1:0]     rd_addr,
  output logic              rd_stall,
  output logic              bus_valid,
  output logic              bus_we,
  output logic [AW-1:0]     bus_addr,
  output logic [DW-1:0]     bus_wdata
);
  import pzo_pkg::*;

  logic [NZONES-1:0] zone_on;
  logic              rd_hit, wr_hit;
  logic              push, rd_go, wr_go;
  logic [AW-1:0]     head_addr;
  logic [DW-1:0]     head_data;
  logic [CW-1:0]     fifo_cnt, prot_cnt;
  bus_op_e           op;

  always_ff @(posedge clk) begin
    if (rst)         zone_on <= EN_RESET;
    else if (cfg_we) zone_on <= cfg_en;
  end

  pzo_zone_match #(.AW(AW), .NZ(NZONES), .ZBASE(ZBASE), .ZLIMIT(ZLIMIT)) u_rmatch (
    .addr(rd_addr), .zone_on(zone_on), .hit(rd_hit));

  pzo_zone_match #(.AW(AW), .NZ(NZONES), .ZBASE(ZBASE), .ZLIMIT(ZLIMIT)) u_wmatch (
    .addr(wr_addr), .zone_on(zone_on), .hit(wr_hit));

  pzo_wfifo #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst),
    .push(push), .push_addr(wr_addr), .push_data(wr_data), .push_prot(wr_hit),
    .pop(wr_go), .head_addr(head_addr), .head_data(head_data),
    .cnt(fifo_cnt), .prot_cnt(prot_cnt));

  pzo_arb #(.DEPTH(DEPTH)) u_arb (
    .rd_valid(rd_valid), .rd_hit(rd_hit), .wr_valid(wr_valid), .wr_hit(wr_hit),
    .cnt(fifo_cnt), .prot_cnt(prot_cnt),
    .push(push), .rd_go(rd_go), .wr_go(wr_go),
    .rd_stall(rd_stall), .wr_stall(wr_stall));

  assign op = wr_go ? OP_WR : OP_RD;

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_valid <= 1'b0;
      bus_we    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
    end else begin
      bus_valid <= rd_go || wr_go;
      bus_we    <= (op == OP_WR);
      if (wr_go) begin
        bus_addr  <= head_addr;
        bus_wdata <= head_data;
      end else if (rd_go) begin
        bus_addr  <= rd_addr;
        bus_wdata <= '0;
      end
    end
  end
endmodule

// File: rtl/pzo_order_chk.sv
module pzo_order_chk #(
  parameter int AW = 16,
  parameter int DEPTH = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          rd_valid,
  input logic [AW-1:0] rd_addr,
  input logic          rd_stall,
  input logic          rd_hit,
  input logic          wr_valid,
  input logic          wr_hit,
  input logic          wr_stall,
  input logic          bus_valid,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [CW-1:0] fifo_cnt,
  input logic [CW-1:0] prot_cnt
);
  assert_reset_idle_R1: assert property (@(posedge clk) rst |=> !bus_valid);

  assert_unprot_nostall_R2: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_hit && prot_cnt == '0 && !(wr_valid && wr_hit) && fifo_cnt != CW'(DEPTH))
    |-> !rd_stall);

  assert_stall_progress_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_stall && fifo_cnt != '0) |=> (bus_valid && bus_we));

  assert_full_drain_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && wr_stall) |-> rd_stall);

  assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (rst)
    fifo_cnt <= CW'(DEPTH));

  assert_read_issue_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_stall) |=> (bus_valid && !bus_we && bus_addr == $past(rd_addr)));
endmodule

bind pzo_order_unit pzo_order_chk #(.AW(AW), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_stall(rd_stall),
  .rd_hit(rd_hit), .wr_valid(wr_valid), .wr_hit(wr_hit), .wr_stall(wr_stall),
  .bus_valid(bus_valid), .bus_we(bus_we), .bus_addr(bus_addr),
  .fifo_cnt(fifo_cnt), .prot_cnt(prot_cnt));

// File: tb/sim_pzo_order_unit.sv
`timescale 1ns/1ps
module sim_pzo_order_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_en = 2'b11;
  logic        wr_valid = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        wr_stall;
  logic        rd_valid = 1'b0;
  logic [15:0] rd_addr = '0;
  logic        rd_stall;
  logic        bus_valid, bus_we;
  logic [15:0] bus_addr, bus_wdata;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  logic        lg_we   [128];
  logic [15:0] lg_addr [128];
  logic [15:0] lg_data [128];
  int          lg_cyc  [128];
  int          lg_n = 0;

  int s_stall, s_racc_cyc, s_wstall_seen, s_drain_bad;

  always #2.5 clk = ~clk;

  pzo_order_unit u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_en(cfg_en),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_stall(wr_stall),
    .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_stall(rd_stall),
    .bus_valid(bus_valid), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata));

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst && bus_valid && lg_n < 128) begin
      lg_we[lg_n]   = bus_we;
      lg_addr[lg_n] = bus_addr;
      lg_data[lg_n] = bus_wdata;
      lg_cyc[lg_n]  = cyc;
      lg_n = lg_n + 1;
    end
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Drives nw writes and nr reads, each stream advancing when its request is accepted.
  task automatic stream(input int nw, input logic [15:0] wa0, input int nr, input logic [15:0] ra0);
    int wi = 0;
    int ri = 0;
    logic wacc, racc;
    s_stall = 0; s_racc_cyc = -1; s_wstall_seen = 0; s_drain_bad = 0;
    @(posedge clk); #1;
    wr_valid = (nw > 0); wr_addr = wa0; wr_data = wa0 ^ 16'h5A5A;
    rd_valid = (nr > 0); rd_addr = ra0;
    while (wi < nw || ri < nr) begin
      @(negedge clk);
      if (rd_valid && rd_stall) s_stall++;
      if (wr_valid && wr_stall) s_wstall_seen = 1;
      if (wr_stall && rd_valid && !rd_stall) s_drain_bad = 1;
      wacc = wr_valid && !wr_stall;
      racc = rd_valid && !rd_stall;
      if (racc && s_racc_cyc < 0) s_racc_cyc = cyc;
      @(posedge clk); #1;
      if (wacc) wi++;
      if (racc) ri++;
      wr_valid = (wi < nw);
      wr_addr  = wa0 + 16'(wi * 2);
      wr_data  = wr_addr ^ 16'h5A5A;
      rd_valid = (ri < nr);
      rd_addr  = ra0 + 16'(ri * 2);
    end
    repeat (12) @(posedge clk);
  endtask

  task automatic t_pair(input string tag, input logic [15:0] wa, input logic [15:0] ra,
                        input int wfirst, input int exp_stall);
    int b = lg_n;
    stream(1, wa, 1, ra);
    chk(tag, "bus transaction count", lg_n - b, 2);
    chk(tag, "read stall cycles", s_stall, exp_stall);
    if (wfirst != 0) begin
      chk(tag, "first op is write", int'(lg_we[b]), 1);
      chk(tag, "first addr", int'(lg_addr[b]), int'(wa));
      chk(tag, "second op is read", int'(lg_we[b+1]), 0);
      chk(tag, "second addr", int'(lg_addr[b+1]), int'(ra));
    end else begin
      chk(tag, "first op is read", int'(lg_we[b]), 0);
      chk(tag, "first addr", int'(lg_addr[b]), int'(ra));
      chk(tag, "second op is write", int'(lg_we[b+1]), 1);
      chk(tag, "write data", int'(lg_data[b+1]), int'(wa ^ 16'h5A5A));
      chk("R8", "read bus cycle after accept", lg_cyc[b], s_racc_cyc + 1);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1", "bus_valid after reset", int'(bus_valid), 0);
    chk("R1", "rd_stall after reset", int'(rd_stall), 0);
    chk("R1", "wr_stall after reset", int'(wr_stall), 0);
  endtask

  task automatic t_cfg(input logic [1:0] en);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_en = en;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic t_full();
    int b = lg_n;
    int nwr = 0;
    int nrd = 0;
    stream(8, 16'h3000, 8, 16'h3100);
    chk("R6", "wr_stall seen when queue full", s_wstall_seen, 1);
    chk("R6", "read passed while queue full", s_drain_bad, 0);
    for (int i = b; i < lg_n; i++) begin
      if (lg_we[i]) begin
        chk("R7", "write order addr", int'(lg_addr[i]), int'(16'h3000 + 16'(nwr * 2)));
        chk("R7", "write data", int'(lg_data[i]), int'(lg_addr[i] ^ 16'h5A5A));
        nwr++;
      end else begin
        nrd++;
      end
    end
    chk("R7", "writes issued", nwr, 8);
    chk("R8", "reads issued", nrd, 8);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_pair("R2", 16'h3000, 16'h3004, 0, 0);
    t_pair("R3", 16'h1010, 16'h1020, 1, 2);   // zones protected from reset (R1)
    t_pair("R4", 16'h6000, 16'h3000, 1, 2);   // write at zone 1 base
    t_pair("R4", 16'h2000, 16'h1FFF, 1, 2);   // read at zone 0 limit
    t_pair("R4", 16'h2000, 16'h0FFF, 0, 0);   // both just outside zone 0
    t_cfg(2'b10);
    t_pair("R5", 16'h1010, 16'h1020, 0, 0);   // zone 0 disabled
    t_pair("R5", 16'h6010, 16'h6020, 1, 2);   // zone 1 still protected
    t_cfg(2'b11);
    t_pair("R5", 16'h1030, 16'h1040, 1, 2);   // zone 0 enabled again
    t_full();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule